// File: doc/BRIEF.md
# Write-Once Coherent Multi-Cache Model

This block holds a handful of small private caches, one per processor, and one shared main-memory array. It keeps every byte coherent under the write-once protocol. A line is Valid while it is clean and may be shared. The first write to a Valid line goes through to memory and removes every other copy, which leaves the line Reserved. Any later write stays inside the cache and leaves the line Dirty. A read miss takes its data from a Dirty copy in another cache when one exists, and that data is also written to memory. Otherwise the data comes from memory. Any exclusive copy elsewhere is demoted to Valid, so that a later write to it again goes through to memory.

Each cache is fully associative and has `NENT` byte entries. Each entry holds a tag, a data byte and a state. Requests arrive one at a time on a valid/ready channel. Each request carries a write flag, a byte address, a processor index and write data. A request is accepted only when `req_ready` is high. `req_ready` stays low from acceptance until the response has been taken. The response is offered on `rsp_valid` and is held with stable data while `rsp_ready` is low. A downstream stall therefore blocks new requests. Two free-running counters report local hits and main-memory accesses.

Top module: `wo_coherent_caches`

## Requirements
- R1: Reset and handshake.
  - After reset, `req_ready` is 1 and `rsp_valid` is 0, and both counters read 0.
  - Every cache entry is Invalid and every memory byte is 0.
  - A request accepted at clock edge k has its response valid after edge k+1.
  - `req_ready` stays 0 from acceptance until the clock edge at which `rsp_valid && rsp_ready`.
  - While `rsp_ready` is 0, `rsp_valid` and `rsp_rdata` hold.
- R2: A read whose address is present in the requesting cache returns that byte. It adds 1 to the hit counter, makes no memory access and changes no state.
- R3: On a read miss with no Dirty copy anywhere, the byte comes from memory (one access) and is filled as Valid. Any Reserved copy in another cache becomes Valid.
- R4: On a read miss while another cache holds the address Dirty, that cache supplies the byte and memory is written with it (one access). Both copies end Valid.
- R5: A write hit on a Valid line updates the cache and memory (one access), invalidates all other copies and leaves the line Reserved. The hit counter adds 1.
- R6: A write hit on a Reserved or Dirty line updates only the local copy, leaves it Dirty and makes no memory access. The hit counter adds 1.
- R7: A write miss fills the line Dirty with the write data and invalidates all other copies.
  - It counts one memory read when no Dirty copy exists elsewhere.
  - It makes no memory access when a Dirty copy is taken over from another cache.
  - The response data of any write is the write data.
- R8: A fill uses the lowest-indexed Invalid entry of the requesting cache. When no entry is Invalid, entry 0 is replaced.
- R9: A Dirty victim is written back to memory, which counts one access. A Valid or Reserved victim is dropped without a memory access.
- R10: At no time does an address sit in more than one entry of a cache. An address held Reserved or Dirty by one cache is held by no other cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_cpu | input | CPW | Requesting processor; indices of NCPU and above change nothing and return 0 |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DW | Read data, or the written byte for a write |
| hit_count | output | CNTW | Local hits since reset |
| mem_count | output | CNTW | Main-memory reads and writes since reset, write-backs included |

## Verification
The bench targets three corner cases.

- Demotion of a Reserved copy on a remote read. Without it, the next write to that copy would stay local and a stale value would remain in memory; the memory counter would then fall one short.
- A full cache that evicts a Dirty line, and a full cache that evicts a Reserved line. A missing write-back shows up when a third cache later reads stale memory. A spurious write-back shows up as an extra count.
- A write miss that takes over another cache's Dirty copy, and a fill that must prefer a free entry over entry 0.

A wrong victim choice turns a later expected hit into a miss. Back-pressure on the response is also held for several cycles to confirm that nothing moves.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_VAL = 2'd1,
    ST_RES = 2'd2,
    ST_DIR = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EXEC = 2'd1,
    PH_RESP = 2'd2
  } phase_t;
endpackage

// File: rtl/wo_mem.sv
module wo_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          pa_en,
  input  logic [AW-1:0] pa_addr,
  input  logic [DW-1:0] pa_data,
  input  logic          pb_en,
  input  logic [AW-1:0] pb_addr,
  input  logic [DW-1:0] pb_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];

  for (genvar m = 0; m < DEPTH; m++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) cell_q[m] <= '0;
      else if (pb_en && pb_addr == AW'(m)) cell_q[m] <= pb_data;
      else if (pa_en && pa_addr == AW'(m)) cell_q[m] <= pa_data;
    end
  end

  assign rd_data = cell_q[rd_addr];

  // a victim never shares the address of the request being served
  AST_WR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n) (pa_en && pb_en) |-> (pa_addr != pb_addr)); // R9
endmodule

// File: rtl/wo_cache_bank.sv
module wo_cache_bank
  import wo_pkg::*;
#(
  parameter int NENT = 2,
  parameter int AW   = 4,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output line_st_t      hit_st,
  output logic [DW-1:0] hit_data,
  output logic [IW-1:0] vic_idx,
  output line_st_t      vic_st,
  output logic [AW-1:0] vic_tag,
  output logic [DW-1:0] vic_data,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [DW-1:0] fill_data,
  input  line_st_t      fill_st,
  input  logic          snp_en,
  input  line_st_t      snp_st
);
  logic [AW-1:0] tag_q [NENT];
  logic [DW-1:0] dat_q [NENT];
  line_st_t      st_q  [NENT];
  logic [NENT-1:0] match;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    assign match[e] = (st_q[e] != ST_INV) && (tag_q[e] == look_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[e]  <= ST_INV;
        tag_q[e] <= '0;
        dat_q[e] <= '0;
      end else if (fill_en && fill_idx == IW'(e)) begin
        st_q[e]  <= fill_st;
        tag_q[e] <= look_addr;
        dat_q[e] <= fill_data;
      end else if (snp_en && match[e]) begin
        st_q[e] <= snp_st;
      end
    end
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    vic_idx = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (match[e]) hit_idx = IW'(e);
      if (st_q[e] == ST_INV) vic_idx = IW'(e);
    end
    hit_st   = st_q[hit_idx];
    hit_data = dat_q[hit_idx];
    vic_st   = st_q[vic_idx];
    vic_tag  = tag_q[vic_idx];
    vic_data = dat_q[vic_idx];
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $countones(match) <= 1); // R10
  AST_FILL_SNOOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fill_en && snp_en)); // R5
endmodule

// File: rtl/wo_ctrl.sv
module wo_ctrl
  import wo_pkg::*;
#(
  parameter int NCPU = 3,
  parameter int NENT = 2,
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int CNTW = 16,
  localparam int CPW = $clog2(NCPU),
  localparam int IW  = $clog2(NENT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [CPW-1:0]            req_cpu,
  input  logic [DW-1:0]             req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [DW-1:0]             rsp_rdata,
  output logic [CNTW-1:0]           hit_count,
  output logic [CNTW-1:0]           mem_count,
  output logic [AW-1:0]             look_addr,
  input  logic [NCPU-1:0]           b_hit,
  input  logic [NCPU-1:0][IW-1:0]   b_hit_idx,
  input  line_st_t [NCPU-1:0]       b_hit_st,
  input  logic [NCPU-1:0][DW-1:0]   b_hit_data,
  input  logic [NCPU-1:0][IW-1:0]   b_vic_idx,
  input  line_st_t [NCPU-1:0]       b_vic_st,
  input  logic [NCPU-1:0][AW-1:0]   b_vic_tag,
  input  logic [NCPU-1:0][DW-1:0]   b_vic_data,
  output logic [NCPU-1:0]           fill_en,
  output logic [IW-1:0]             fill_idx,
  output logic [DW-1:0]             fill_data,
  output line_st_t                  fill_st,
  output logic [NCPU-1:0]           snp_en,
  output line_st_t                  snp_st,
  input  logic [DW-1:0]             mem_rd_data,
  output logic                      wb_en,
  output logic [AW-1:0]             wb_addr,
  output logic [DW-1:0]             wb_data,
  output logic                      up_en,
  output logic [DW-1:0]             up_data
);
  phase_t         ph_q;
  logic [AW-1:0]  addr_q;
  logic [CPW-1:0] cpu_q;
  logic           wr_q;
  logic [DW-1:0]  wd_q;
  logic [DW-1:0]  rdata_q;
  logic [CNTW-1:0] hit_q, macc_q;

  logic           cpu_ok, l_hit, o_dirty, vic_dirty, hit_inc;
  line_st_t       l_st;
  logic [IW-1:0]  l_hidx, l_vidx;
  logic [DW-1:0]  l_hdata, o_data, rdata_d;
  logic [NCPU-1:0] others;
  logic [1:0]     macc_inc;
  logic [NCPU-1:0] excl;

  assign look_addr = addr_q;
  assign req_ready = (ph_q == PH_IDLE);
  assign rsp_valid = (ph_q == PH_RESP);
  assign rsp_rdata = rdata_q;
  assign hit_count = hit_q;
  assign mem_count = macc_q;

  // gather the requester's view and the snoop view of every other cache
  always_comb begin
    cpu_ok    = 1'b0;
    l_hit     = 1'b0;
    l_st      = ST_INV;
    l_hidx    = '0;
    l_hdata   = '0;
    l_vidx    = '0;
    vic_dirty = 1'b0;
    wb_addr   = '0;
    wb_data   = '0;
    others    = '0;
    o_dirty   = 1'b0;
    o_data    = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (CPW'(i) == cpu_q) begin
        cpu_ok    = 1'b1;
        l_hit     = b_hit[i];
        l_st      = b_hit_st[i];
        l_hidx    = b_hit_idx[i];
        l_hdata   = b_hit_data[i];
        l_vidx    = b_vic_idx[i];
        vic_dirty = (b_vic_st[i] == ST_DIR);
        wb_addr   = b_vic_tag[i];
        wb_data   = b_vic_data[i];
      end else if (b_hit[i]) begin
        others[i] = 1'b1;
        if (b_hit_st[i] == ST_DIR) begin
          o_dirty = 1'b1;
          o_data  = b_hit_data[i];
        end
      end
    end
  end

  // protocol decision for the request held in the execute phase
  always_comb begin
    fill_en   = '0;
    fill_idx  = l_vidx;
    fill_data = wd_q;
    fill_st   = ST_DIR;
    snp_en    = '0;
    snp_st    = ST_INV;
    wb_en     = 1'b0;
    up_en     = 1'b0;
    up_data   = wd_q;
    hit_inc   = 1'b0;
    macc_inc  = 2'd0;
    rdata_d   = '0;
    if (ph_q == PH_EXEC && cpu_ok) begin
      if (!wr_q) begin
        if (l_hit) begin
          rdata_d = l_hdata;
          hit_inc = 1'b1;
        end else begin
          rdata_d  = o_dirty ? o_data : mem_rd_data;
          fill_en  = NCPU'(1) << cpu_q;
          fill_data = rdata_d;
          fill_st  = ST_VAL;
          snp_en   = others;
          snp_st   = ST_VAL;
          up_en    = o_dirty;
          up_data  = o_data;
          wb_en    = vic_dirty;
          macc_inc = 2'd1 + {1'b0, vic_dirty};
        end
      end else begin
        rdata_d = wd_q;
        fill_en = NCPU'(1) << cpu_q;
        if (l_hit) begin
          hit_inc  = 1'b1;
          fill_idx = l_hidx;
          if (l_st == ST_VAL) begin
            fill_st  = ST_RES;
            up_en    = 1'b1;
            snp_en   = others;
            macc_inc = 2'd1;
          end
        end else begin
          snp_en   = others;
          wb_en    = vic_dirty;
          macc_inc = {1'b0, !o_dirty} + {1'b0, vic_dirty};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      cpu_q   <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      rdata_q <= '0;
      hit_q   <= '0;
      macc_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          cpu_q  <= req_cpu;
          wr_q   <= req_write;
          wd_q   <= req_wdata;
          ph_q   <= PH_EXEC;
        end
        PH_EXEC: begin
          rdata_q <= rdata_d;
          hit_q   <= hit_q + CNTW'(hit_inc);
          macc_q  <= macc_q + CNTW'(macc_inc);
          ph_q    <= PH_RESP;
        end
        PH_RESP: if (rsp_ready) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NCPU; i++)
      excl[i] = b_hit[i] && (b_hit_st[i] == ST_RES || b_hit_st[i] == ST_DIR);
  end

  AST_EXCL_ALONE: assert property (@(posedge clk) disable iff (!rst_n) (|excl) |-> ($countones(b_hit) == 1)); // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !req_ready); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R1
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (hit_count - $past(hit_count)) <= CNTW'(1)); // R2
  AST_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n) (mem_count - $past(mem_count)) <= CNTW'(2)); // R9
endmodule

// File: rtl/wo_coherent_caches.sv
module wo_coherent_caches
  import wo_pkg::*;
#(
  parameter int NCPU = 3,
  parameter int NENT = 2,
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int CNTW = 16,
  localparam int CPW = $clog2(NCPU),
  localparam int IW  = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [CPW-1:0]  req_cpu,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  output logic [CNTW-1:0] hit_count,
  output logic [CNTW-1:0] mem_count
);
  logic [AW-1:0]             look_addr;
  logic [NCPU-1:0]           b_hit;
  logic [NCPU-1:0][IW-1:0]   b_hit_idx, b_vic_idx;
  line_st_t [NCPU-1:0]       b_hit_st, b_vic_st;
  logic [NCPU-1:0][DW-1:0]   b_hit_data, b_vic_data;
  logic [NCPU-1:0][AW-1:0]   b_vic_tag;
  logic [NCPU-1:0]           fill_en, snp_en;
  logic [IW-1:0]             fill_idx;
  logic [DW-1:0]             fill_data, mem_rd_data, wb_data, up_data;
  line_st_t                  fill_st, snp_st;
  logic                      wb_en, up_en;
  logic [AW-1:0]             wb_addr;

  wo_ctrl #(.NCPU(NCPU), .NENT(NENT), .AW(AW), .DW(DW), .CNTW(CNTW)) u_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_cpu, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .hit_count, .mem_count, .look_addr,
    .b_hit, .b_hit_idx, .b_hit_st, .b_hit_data, .b_vic_idx, .b_vic_st, .b_vic_tag, .b_vic_data,
    .fill_en, .fill_idx, .fill_data, .fill_st, .snp_en, .snp_st,
    .mem_rd_data, .wb_en, .wb_addr, .wb_data, .up_en, .up_data
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_bank
    wo_cache_bank #(.NENT(NENT), .AW(AW), .DW(DW)) u_bank (
      .clk, .rst_n, .look_addr,
      .hit(b_hit[c]), .hit_idx(b_hit_idx[c]), .hit_st(b_hit_st[c]), .hit_data(b_hit_data[c]),
      .vic_idx(b_vic_idx[c]), .vic_st(b_vic_st[c]), .vic_tag(b_vic_tag[c]), .vic_data(b_vic_data[c]),
      .fill_en(fill_en[c]), .fill_idx, .fill_data, .fill_st,
      .snp_en(snp_en[c]), .snp_st
    );
  end

  wo_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk, .rst_n,
    .rd_addr(look_addr), .rd_data(mem_rd_data),
    .pa_en(wb_en), .pa_addr(wb_addr), .pa_data(wb_data),
    .pb_en(up_en), .pb_addr(look_addr), .pb_data(up_data)
  );
endmodule

// File: tb/wo_coherent_caches_tb.sv
module wo_coherent_caches_tb;
  localparam int NC = 3, NE = 2, AW = 4, DW = 8, CNTW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_cpu = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [CNTW-1:0] hit_count, mem_count;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wo_coherent_caches u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_cpu, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .hit_count, .mem_count
  );

  // behavioural reference: states 0 invalid, 1 valid, 2 reserved, 3 dirty
  int m_ph = 0, m_hit = 0, m_acc = 0, m_rd = 0;
  int m_w, m_a, m_c, m_d;
  int m_st [NC][NE];
  int m_tag[NC][NE];
  int m_dat[NC][NE];
  int m_mem[16];

  task automatic model_exec();
    int li, od, oe, vi;
    li = -1; od = -1; oe = 0; vi = 0;
    for (int e = 0; e < NE; e++)
      if (m_st[m_c][e] != 0 && m_tag[m_c][e] == m_a) li = e;
    for (int i = 0; i < NC; i++)
      for (int e = 0; e < NE; e++)
        if (i != m_c && m_st[i][e] == 3 && m_tag[i][e] == m_a) begin od = i; oe = e; end
    for (int e = NE - 1; e >= 0; e--) if (m_st[m_c][e] == 0) vi = e;
    if (m_w == 0 && li >= 0) begin
      m_rd = m_dat[m_c][li]; m_hit++;
    end else if (m_w == 0) begin
      if (od >= 0) begin m_rd = m_dat[od][oe]; m_mem[m_a] = m_rd; end
      else m_rd = m_mem[m_a];
      m_acc++;
      if (m_st[m_c][vi] == 3) begin m_mem[m_tag[m_c][vi]] = m_dat[m_c][vi]; m_acc++; end
      for (int i = 0; i < NC; i++)
        for (int e = 0; e < NE; e++)
          if (i != m_c && m_st[i][e] != 0 && m_tag[i][e] == m_a) m_st[i][e] = 1;
      m_st[m_c][vi] = 1; m_tag[m_c][vi] = m_a; m_dat[m_c][vi] = m_rd;
    end else begin
      m_rd = m_d;
      if (li >= 0) begin
        m_hit++;
        m_dat[m_c][li] = m_d;
        if (m_st[m_c][li] == 1) begin
          m_st[m_c][li] = 2; m_mem[m_a] = m_d; m_acc++;
          for (int i = 0; i < NC; i++)
            for (int e = 0; e < NE; e++)
              if (i != m_c && m_tag[i][e] == m_a) m_st[i][e] = 0;
        end else m_st[m_c][li] = 3;
      end else begin
        if (od < 0) m_acc++;
        if (m_st[m_c][vi] == 3) begin m_mem[m_tag[m_c][vi]] = m_dat[m_c][vi]; m_acc++; end
        for (int i = 0; i < NC; i++)
          for (int e = 0; e < NE; e++)
            if (i != m_c && m_tag[i][e] == m_a) m_st[i][e] = 0;
        m_st[m_c][vi] = 3; m_tag[m_c][vi] = m_a; m_dat[m_c][vi] = m_d;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_hit = 0; m_acc = 0; m_rd = 0;
      for (int i = 0; i < NC; i++)
        for (int e = 0; e < NE; e++) begin m_st[i][e] = 0; m_tag[i][e] = 0; m_dat[i][e] = 0; end
      for (int k = 0; k < 16; k++) m_mem[k] = 0;
    end else begin
      case (m_ph)
        0: if (req_valid) begin
          m_w = int'(req_write); m_a = int'(req_addr); m_c = int'(req_cpu); m_d = int'(req_wdata);
          m_ph = 1;
        end
        1: begin model_exec(); m_ph = 2; end
        default: if (rsp_ready) m_ph = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clock-by-clock comparison against the reference, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready === (m_ph == 0), "R1 req_ready", int'(req_ready), int'(m_ph == 0));
      check(rsp_valid === (m_ph == 2), "R1 rsp_valid", int'(rsp_valid), int'(m_ph == 2));
      if (m_ph == 2) check(int'(rsp_rdata) == m_rd, "R3 model data", int'(rsp_rdata), m_rd);
      check(int'(hit_count) == m_hit, "R2 model hits", int'(hit_count), m_hit);
      check(int'(mem_count) == m_acc, "R9 model accesses", int'(mem_count), m_acc);
    end
  end

  // one request with hand-derived expectations
  task automatic do_req(input bit w, input int a, input int c, input int d,
                        input int exp_d, input int dh, input int dm, input int hold, input string req);
    int h0, a0;
    @(negedge clk);
    h0 = int'(hit_count); a0 = int'(mem_count);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_cpu = 2'(c); req_wdata = DW'(d);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && int'(rsp_rdata) == exp_d, {req, " R1 hold"}, int'(rsp_rdata), exp_d);
    end
    check(int'(rsp_rdata) == exp_d, {req, " data"}, int'(rsp_rdata), exp_d);
    check(int'(hit_count) - h0 == dh, {req, " hit delta"}, int'(hit_count) - h0, dh);
    check(int'(mem_count) - a0 == dm, {req, " access delta"}, int'(mem_count) - a0, dm);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1 reset handshake", int'({req_ready, rsp_valid}), 2);
    check(hit_count == 0 && mem_count == 0, "R1 reset counters", int'(mem_count), 0);
    do_req(1, 1, 0, 'h11, 'h11, 0, 1, 0, "R7 write miss fetch");
    do_req(0, 1, 1, 0, 'h11, 0, 1, 0, "R4 dirty supplier");
    do_req(0, 1, 1, 0, 'h11, 1, 0, 3, "R2 read hit with R1 stall");
    do_req(1, 1, 1, 'h22, 'h22, 1, 1, 0, "R5 write hit valid");
    do_req(0, 1, 0, 0, 'h22, 0, 1, 0, "R3 miss memory after R5");
    do_req(1, 1, 1, 'h33, 'h33, 1, 1, 0, "R3 demoted reserved writes through");
    do_req(1, 1, 1, 'h44, 'h44, 1, 0, 0, "R6 reserved to dirty");
    do_req(1, 1, 1, 'h55, 'h55, 1, 0, 0, "R6 dirty stays local");
    do_req(0, 2, 1, 0, 'h00, 0, 1, 0, "R8 free entry fill");
    do_req(0, 3, 1, 0, 'h00, 0, 2, 0, "R9 dirty victim write-back");
    do_req(0, 1, 2, 0, 'h55, 0, 1, 0, "R9 written-back value");
    do_req(0, 4, 1, 0, 'h00, 0, 1, 0, "R9 clean victim dropped");
    do_req(1, 5, 2, 'h66, 'h66, 0, 1, 0, "R8 invalid entry preferred");
    do_req(0, 1, 2, 0, 'h55, 1, 0, 0, "R8 entry 0 kept");
    do_req(1, 1, 2, 'h77, 'h77, 1, 1, 0, "R5 write through");
    do_req(0, 6, 2, 0, 'h00, 0, 1, 0, "R9 reserved victim dropped");
    do_req(0, 1, 0, 0, 'h77, 0, 1, 0, "R9 memory current after drop");
    do_req(1, 5, 0, 'h88, 'h88, 0, 0, 0, "R7 take over dirty copy");
    do_req(0, 5, 2, 0, 'h88, 0, 1, 0, "R4 supply after takeover");
    do_req(0, 5, 1, 0, 'h88, 0, 1, 0, "R4 memory updated R10");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule